// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Address-Space Tags

The block caches page-table entries so that virtual addresses can be turned into physical addresses without a table walk. A virtual address is 64 bits and a physical address is 40 bits. Pages are 16 KB, so the low 14 bits of the address pass through untouched. The virtual page number (50 bits) is translated into a 26-bit physical frame number. The store holds 256 entries as 128 sets of 2 ways. The set is chosen by the low 7 bits of the virtual page number. The tag is the upper 43 page-number bits together with an 8-bit address-space identifier. Because of that identifier, entries from several contexts can live side by side, and a context switch needs no flush.

A lookup is combinational against the registered arrays. In the same cycle it returns the hit flag, the physical address, a fault code, and the entry's reference and dirty bits as they stood before the access. The bits are updated at the next clock edge. Entries are written through a refill port by an outside table walker. A flush input empties the whole store in one cycle.

There is no back-pressure on either port: a lookup or refill presented with its valid high is taken in that cycle. Results are qualified by `lk_valid` only, and the caller never has to wait.

Top module: `tlb_xlate`

## Requirements
- R1: When a valid entry matches both the page number and the address-space identifier, and the access is permitted, `lk_hit` is 1 and `lk_fault` is 00 in the same cycle. `lk_paddr` is the stored frame number followed by `lk_vaddr[13:0]` unchanged.
- R2: When no valid entry matches, the result is a page fault: `lk_fault` = 01, `lk_hit` = 0, `lk_paddr` = 0. A difference in any page-number bit, including bit 63, gives a miss.
- R3: The protection code is 00 for read-only, 01 for read/write, and 1x for system-only. A user access (`lk_user`=1) to a 1x page is refused, and so is a write to a 00 page. A refused access gives `lk_fault` = 10, `lk_hit` = 0 and `lk_paddr` = 0.
- R4: Entries that share a page number but differ in address-space identifier coexist in one set. A lookup matches only the entry with its own identifier.
- R5: `lk_ref` and `lk_dirty` report the matched entry's bits as they were before the access. A permitted access sets the reference bit from the next cycle on. A permitted write also sets the dirty bit. A refused access changes neither bit, and a refill clears both.
- R6: A refill whose page number and identifier are already present overwrites that same way, leaving the other way of the set intact. Otherwise a refill takes an invalid way if one exists. The written entry can be looked up from the next cycle.
- R7: Two keys that share a set are both resident. A third key refilled into a full set evicts exactly one of the two, chosen by a free-running pseudo-random bit.
- R8: `flush` invalidates every entry in one cycle. A refill in the same cycle as a flush is dropped.
- R9: After reset every entry is invalid, so every lookup reports a page fault.
- R10: With `lk_valid` = 0, `lk_hit` is 0, `lk_fault` is 00, `lk_paddr` is 0, and no reference or dirty bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 64 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the access |
| lk_write | input | 1 | 1 for a write, 0 for a read |
| lk_user | input | 1 | 1 for a user-mode access, 0 for system mode |
| lk_hit | output | 1 | Translation delivered |
| lk_paddr | output | 40 | Physical address, zero unless hit |
| lk_fault | output | 2 | 00 none, 01 page not resident, 10 protection |
| lk_ref | output | 1 | Matched entry's reference bit before this access |
| lk_dirty | output | 1 | Matched entry's dirty bit before this access |
| rf_valid | input | 1 | Refill entry present |
| rf_vpn | input | 50 | Virtual page number of the refill |
| rf_asid | input | 8 | Address-space identifier of the refill |
| rf_pfn | input | 26 | Physical frame number of the refill |
| rf_prot | input | 2 | Protection code of the refill |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest state to reach is a set that is already full when a third key arrives, because the evicted way depends on a pseudo-random bit the ports cannot see. The directed part fills one set with three keys that differ only in identifier. It then checks that the newest key hits and that exactly one older key survives, whichever one that is. The random part draws keys from a pool that puts two keys, with equal page numbers and different identifiers, into each of sixteen sets. This keeps the expected contents exact. Refills, permitted and refused reads and writes, and flushes are interleaved, so reference and dirty reporting is checked after every mix of prior accesses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } flt_e;

  localparam logic [1:0] PROT_RDONLY = 2'b00;
  localparam logic [1:0] PROT_RDWR   = 2'b01;
  localparam int         PROT_SYS_B  = 1;   // set: system-only page

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int LFSR_W = 16,
  parameter int OUT_W  = 1,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  // taps for x^16 + x^14 + x^13 + x^11 + 1
  assign fb = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-3] ^ lfsr_q[LFSR_W-4] ^ lfsr_q[LFSR_W-6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  assign rnd = lfsr_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R7

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 43,
  parameter int ASID_W = 8,
  parameter int WAY_W  = 1
) (
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
  input  logic [WAYS-1:0][ASID_W-1:0] set_asid,
  input  logic [TAG_W-1:0]            key_tag,
  input  logic [ASID_W-1:0]           key_asid,
  output logic [WAYS-1:0]             match,
  output logic                        any,
  output logic [WAY_W-1:0]            way
);

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
    assign match[gw] = set_valid[gw] && (set_tag[gw] == key_tag)
                       && (set_asid[gw] == key_asid);
  end

  assign any = |match;

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic             any_match,
  input  logic [WAY_W-1:0] match_way,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] way
);

  logic [WAY_W-1:0] free_way;
  logic             has_free;

  // lowest-numbered invalid way
  always_comb begin
    free_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        free_way = WAY_W'(w);
        has_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_match)     way = match_way;
    else if (has_free) way = free_way;
    else               way = rnd;
  end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [1:0] prot,
  input  logic       user,
  input  logic       write,
  output logic       deny
);

  logic sys_only;
  logic rd_only;

  assign sys_only = prot[PROT_SYS_B];
  assign rd_only  = (prot == PROT_RDONLY);
  assign deny     = (user && sys_only) || (write && rd_only);

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 14,
  parameter int ENTRIES   = 256,
  parameter int WAYS      = 2,
  parameter int ASID_W    = 8,
  parameter int LFSR_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  input  logic [ASID_W-1:0]    lk_asid,
  input  logic                 lk_write,
  input  logic                 lk_user,
  output logic                 lk_hit,
  output logic [PA_W-1:0]      lk_paddr,
  output logic [1:0]           lk_fault,
  output logic                 lk_ref,
  output logic                 lk_dirty,
  input  logic                 rf_valid,
  input  logic [VA_W-PAGE_BITS-1:0] rf_vpn,
  input  logic [ASID_W-1:0]    rf_asid,
  input  logic [PA_W-PAGE_BITS-1:0] rf_pfn,
  input  logic [1:0]           rf_prot,
  input  logic                 flush
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_W = IDX_W + WAY_W;

  // ---------------- storage ----------------
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [1:0]         prot_q [ENTRIES];

  function automatic logic [ENT_W-1:0] ent_of(input logic [IDX_W-1:0] s,
                                              input logic [WAY_W-1:0] w);
    return {s, w};
  endfunction

  // ---------------- lookup side ----------------
  logic [VPN_W-1:0]               lk_vpn;
  logic [IDX_W-1:0]               lk_idx;
  logic [TAG_W-1:0]               lk_tag;
  logic [WAYS-1:0]                lk_set_valid;
  logic [WAYS-1:0][TAG_W-1:0]     lk_set_tag;
  logic [WAYS-1:0][ASID_W-1:0]    lk_set_asid;
  logic [WAYS-1:0]                lk_match;
  logic                           lk_any;
  logic [WAY_W-1:0]               lk_way;
  logic [ENT_W-1:0]               lk_ent;
  logic                           lk_deny;

  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_set_valid[w] = valid_q[ent_of(lk_idx, WAY_W'(w))];
      lk_set_tag[w]   = tag_q[ent_of(lk_idx, WAY_W'(w))];
      lk_set_asid[w]  = asid_q[ent_of(lk_idx, WAY_W'(w))];
    end
  end

  tlb_way_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .WAY_W(WAY_W)
  ) u_lk_match (
    .set_valid (lk_set_valid),
    .set_tag   (lk_set_tag),
    .set_asid  (lk_set_asid),
    .key_tag   (lk_tag),
    .key_asid  (lk_asid),
    .match     (lk_match),
    .any       (lk_any),
    .way       (lk_way)
  );

  assign lk_ent = ent_of(lk_idx, lk_way);

  tlb_perm u_perm (
    .prot  (prot_q[lk_ent]),
    .user  (lk_user),
    .write (lk_write),
    .deny  (lk_deny)
  );

  always_comb begin
    lk_hit   = lk_valid && lk_any && !lk_deny;
    lk_ref   = lk_valid && lk_any && ref_q[lk_ent];
    lk_dirty = lk_valid && lk_any && dirty_q[lk_ent];
    if (!lk_valid)    lk_fault = FLT_NONE;
    else if (!lk_any) lk_fault = FLT_PAGE;
    else if (lk_deny) lk_fault = FLT_PROT;
    else              lk_fault = FLT_NONE;
    lk_paddr = lk_hit ? {pfn_q[lk_ent], lk_vaddr[PAGE_BITS-1:0]} : '0;
  end

  // ---------------- refill side ----------------
  logic [IDX_W-1:0]               rf_idx;
  logic [TAG_W-1:0]               rf_tag;
  logic [WAYS-1:0]                rf_set_valid;
  logic [WAYS-1:0][TAG_W-1:0]     rf_set_tag;
  logic [WAYS-1:0][ASID_W-1:0]    rf_set_asid;
  logic [WAYS-1:0]                rf_match;
  logic                           rf_any;
  logic [WAY_W-1:0]               rf_match_way;
  logic [WAY_W-1:0]               rf_way;
  logic [WAY_W-1:0]               rnd_way;
  logic [ENT_W-1:0]               rf_ent;
  logic                           rf_take;

  assign rf_idx  = rf_vpn[IDX_W-1:0];
  assign rf_tag  = rf_vpn[VPN_W-1:IDX_W];
  assign rf_take = rf_valid && !flush;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rf_set_valid[w] = valid_q[ent_of(rf_idx, WAY_W'(w))];
      rf_set_tag[w]   = tag_q[ent_of(rf_idx, WAY_W'(w))];
      rf_set_asid[w]  = asid_q[ent_of(rf_idx, WAY_W'(w))];
    end
  end

  tlb_way_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W), .WAY_W(WAY_W)
  ) u_rf_match (
    .set_valid (rf_set_valid),
    .set_tag   (rf_set_tag),
    .set_asid  (rf_set_asid),
    .key_tag   (rf_tag),
    .key_asid  (rf_asid),
    .match     (rf_match),
    .any       (rf_any),
    .way       (rf_match_way)
  );

  tlb_lfsr #(
    .LFSR_W (LFSR_W),
    .OUT_W  (WAY_W)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd   (rnd_way)
  );

  tlb_victim #(
    .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_victim (
    .set_valid (rf_set_valid),
    .any_match (rf_any),
    .match_way (rf_match_way),
    .rnd       (rnd_way),
    .way       (rf_way)
  );

  assign rf_ent = ent_of(rf_idx, rf_way);

  // ---------------- state update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (lk_hit) begin
        ref_q[lk_ent] <= 1'b1;
        if (lk_write) dirty_q[lk_ent] <= 1'b1;
      end
      if (flush) begin
        valid_q <= '0;
      end else if (rf_valid) begin
        valid_q[rf_ent] <= 1'b1;
        ref_q[rf_ent]   <= 1'b0;
        dirty_q[rf_ent] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rf_take) begin
      tag_q[rf_ent]  <= rf_tag;
      asid_q[rf_ent] <= rf_asid;
      pfn_q[rf_ent]  <= rf_pfn;
      prot_q[rf_ent] <= rf_prot;
    end
  end

  // ---------------- assertions ----------------
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(lk_match)); // R6

  AST_FAULT_GIVES_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_fault != FLT_NONE) |-> (!lk_hit && lk_paddr == '0)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_fault == FLT_NONE)); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R8

  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_take |=> valid_q[$past(rf_ent)]); // R6

  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_any && !(&rf_set_valid)) |-> !rf_set_valid[rf_way]); // R6

  AST_DIRTY_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~ref_q & valid_q) == '0); // R5

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [63:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_write;
  logic        lk_user;
  logic        lk_hit;
  logic [39:0] lk_paddr;
  logic [1:0]  lk_fault;
  logic        lk_ref;
  logic        lk_dirty;
  logic        rf_valid;
  logic [49:0] rf_vpn;
  logic [7:0]  rf_asid;
  logic [25:0] rf_pfn;
  logic [1:0]  rf_prot;
  logic        flush;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
    .lk_ref(lk_ref), .lk_dirty(lk_dirty),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
    .rf_pfn(rf_pfn), .rf_prot(rf_prot), .flush(flush)
  );

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [44:0] pack(input bit h, input logic [1:0] f,
                                       input bit r, input bit d, input logic [39:0] pa);
    return {h, f, r, d, pa};
  endfunction

  function automatic bit deny_f(input logic [1:0] prot, input bit w, input bit u);
    return (u && prot[1]) || (w && prot == 2'b00);
  endfunction

  task automatic clear_in();
    lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_write = 0; lk_user = 0;
    rf_valid = 0; rf_vpn = '0; rf_asid = '0; rf_pfn = '0; rf_prot = '0; flush = 0;
  endtask

  task automatic look(input logic [63:0] va, input logic [7:0] asid,
                      input bit w, input bit u, output logic [44:0] res);
    @(negedge clk);
    clear_in();
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_write = w; lk_user = u;
    #1;
    res = {lk_hit, lk_fault, lk_ref, lk_dirty, lk_paddr};
  endtask

  task automatic fill(input logic [49:0] vpn, input logic [7:0] asid,
                      input logic [25:0] pfn, input logic [1:0] prot, input bit fl);
    @(negedge clk);
    clear_in();
    rf_valid = 1; rf_vpn = vpn; rf_asid = asid; rf_pfn = pfn; rf_prot = prot; flush = fl;
  endtask

  task automatic do_flush();
    @(negedge clk);
    clear_in();
    flush = 1;
  endtask

  // key pool: two keys per set, same page number, different identifier
  function automatic logic [49:0] key_vpn(input int k);
    logic [42:0] t;
    logic [6:0]  s;
    t = 43'h2_1357_9BDF ^ 43'(k / 2);
    s = 7'((k / 2) * 7 + 3);
    return {t, s};
  endfunction

  function automatic logic [7:0] key_asid(input int k);
    return 8'h10 + 8'(k / 2) + ((k % 2) != 0 ? 8'h80 : 8'h00);
  endfunction

  bit          m_present [32];
  logic [25:0] m_pfn     [32];
  logic [1:0]  m_prot    [32];
  bit          m_ref     [32];
  bit          m_dirty   [32];

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [44:0] res;
    logic [49:0] v0, va_, vb_, vc_;
    int hits_ab;
    void'($urandom(32'd20240611));
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    v0 = key_vpn(0);

    // R9: empty after reset
    look({v0, 14'h0123}, key_asid(0), 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R9", "lookup after reset", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));

    // R10: idle lookup gives nothing and touches nothing
    fill(v0, key_asid(0), 26'h0ABCDE, 2'b01, 0);
    @(negedge clk);
    clear_in();
    lk_valid = 0; lk_vaddr = {v0, 14'h0010}; lk_asid = key_asid(0); lk_write = 1;
    #1;
    res = {lk_hit, lk_fault, lk_ref, lk_dirty, lk_paddr};
    chk(res == '0, "R10", "idle outputs", 64'(res), 64'h0);

    // R1 + R10: first real lookup reports ref 0 (idle cycle did not touch)
    look({v0, 14'h0010}, key_asid(0), 0, 0, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'h0ABCDE, 14'h0010}), "R1", "read hit",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'h0ABCDE, 14'h0010})));

    // R5: write after read sees ref 1 dirty 0, then read sees both set
    look({v0, 14'h0020}, key_asid(0), 1, 1, res);
    chk(res == pack(1, 2'b00, 1, 0, {26'h0ABCDE, 14'h0020}), "R5", "write after read",
        64'(res), 64'(pack(1, 2'b00, 1, 0, {26'h0ABCDE, 14'h0020})));
    look({v0, 14'h3FFF}, key_asid(0), 0, 1, res);
    chk(res == pack(1, 2'b00, 1, 1, {26'h0ABCDE, 14'h3FFF}), "R5", "read after write",
        64'(res), 64'(pack(1, 2'b00, 1, 1, {26'h0ABCDE, 14'h3FFF})));

    // R2: top address bit differs
    look({v0 ^ (50'd1 << 49), 14'h0}, key_asid(0), 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R2", "bit 63 differs", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));

    // R4: other identifier misses, then coexists
    look({v0, 14'h0}, key_asid(1), 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R4", "foreign id miss", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));
    fill(v0, key_asid(1), 26'h1111, 2'b00, 0);
    look({v0, 14'h5}, key_asid(1), 0, 1, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'h1111, 14'h5}), "R4", "second id hit",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'h1111, 14'h5})));
    look({v0, 14'h6}, key_asid(0), 0, 0, res);
    chk(res == pack(1, 2'b00, 1, 1, {26'h0ABCDE, 14'h6}), "R4", "first id kept",
        64'(res), 64'(pack(1, 2'b00, 1, 1, {26'h0ABCDE, 14'h6})));

    // R3: read-only page refuses a write and is not touched (R5)
    fill(key_vpn(4), key_asid(4), 26'h2222, 2'b00, 0);
    look({key_vpn(4), 14'h7}, key_asid(4), 1, 0, res);
    chk(res == pack(0, 2'b10, 0, 0, '0), "R3", "write to read-only", 64'(res), 64'(pack(0, 2'b10, 0, 0, '0)));
    look({key_vpn(4), 14'h7}, key_asid(4), 0, 1, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'h2222, 14'h7}), "R5", "refused access left ref clear",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'h2222, 14'h7})));

    // R3: system-only page
    fill(key_vpn(6), key_asid(6), 26'h3333, 2'b10, 0);
    look({key_vpn(6), 14'h8}, key_asid(6), 0, 1, res);
    chk(res == pack(0, 2'b10, 0, 0, '0), "R3", "user read of system page", 64'(res), 64'(pack(0, 2'b10, 0, 0, '0)));
    look({key_vpn(6), 14'h8}, key_asid(6), 1, 0, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'h3333, 14'h8}), "R3", "system write of system page",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'h3333, 14'h8})));

    // R6: refill of a present key overwrites its own way, neighbour survives, bits cleared
    fill(v0, key_asid(0), 26'h0F0F0, 2'b01, 0);
    look({v0, 14'h9}, key_asid(0), 0, 0, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'h0F0F0, 14'h9}), "R6", "overwrite in place",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'h0F0F0, 14'h9})));
    look({v0, 14'h9}, key_asid(1), 0, 0, res);
    chk(res == pack(1, 2'b00, 1, 0, {26'h1111, 14'h9}), "R6", "neighbour kept",
        64'(res), 64'(pack(1, 2'b00, 1, 0, {26'h1111, 14'h9})));

    // R7: third key into a full set evicts exactly one
    va_ = {43'h7ABC, 7'd100}; vb_ = va_; vc_ = va_;
    fill(va_, 8'd1, 26'hA, 2'b01, 0);
    fill(vb_, 8'd2, 26'hB, 2'b01, 0);
    fill(vc_, 8'd3, 26'hC, 2'b01, 0);
    look({vc_, 14'h1}, 8'd3, 0, 0, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'hC, 14'h1}), "R7", "newest key hits",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'hC, 14'h1})));
    hits_ab = 0;
    look({va_, 14'h1}, 8'd1, 0, 0, res); hits_ab += int'(res[44]);
    look({vb_, 14'h1}, 8'd2, 0, 0, res); hits_ab += int'(res[44]);
    chk(hits_ab == 1, "R7", "survivors of full set", 64'(hits_ab), 64'd1);
    fill(vc_, 8'd3, 26'hD, 2'b01, 0);
    look({vc_, 14'h2}, 8'd3, 0, 0, res);
    chk(res == pack(1, 2'b00, 0, 0, {26'hD, 14'h2}), "R6", "overwrite in full set",
        64'(res), 64'(pack(1, 2'b00, 0, 0, {26'hD, 14'h2})));
    hits_ab = 0;
    look({va_, 14'h1}, 8'd1, 0, 0, res); hits_ab += int'(res[44]);
    look({vb_, 14'h1}, 8'd2, 0, 0, res); hits_ab += int'(res[44]);
    chk(hits_ab == 1, "R6", "overwrite evicted nothing", 64'(hits_ab), 64'd1);

    // R8: flush empties; refill together with flush is dropped
    do_flush();
    look({v0, 14'h0}, key_asid(1), 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R8", "after flush", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));
    look({vc_, 14'h0}, 8'd3, 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R8", "after flush other set", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));
    fill(v0, key_asid(0), 26'h55, 2'b01, 1);
    look({v0, 14'h0}, key_asid(0), 0, 0, res);
    chk(res == pack(0, 2'b01, 0, 0, '0), "R8", "refill dropped by flush", 64'(res), 64'(pack(0, 2'b01, 0, 0, '0)));

    // ---------------- random phase against the pool model ----------------
    for (int k = 0; k < 32; k++) begin
      m_present[k] = 0; m_ref[k] = 0; m_dirty[k] = 0; m_pfn[k] = '0; m_prot[k] = '0;
    end
    for (int i = 0; i < 4000; i++) begin
      int r;
      int k;
      r = int'($urandom % 100);
      k = int'($urandom % 32);
      if (r < 30) begin
        logic [25:0] p;
        logic [1:0]  pr;
        p  = 26'($urandom);
        pr = 2'($urandom);
        fill(key_vpn(k), key_asid(k), p, pr, 0);
        m_present[k] = 1; m_pfn[k] = p; m_prot[k] = pr; m_ref[k] = 0; m_dirty[k] = 0;
      end else if (r < 97) begin
        logic [13:0] off;
        bit w, u, foreign;
        logic [44:0] exp;
        off = 14'($urandom);
        w = 1'($urandom); u = 1'($urandom);
        foreign = (($urandom % 10) == 0);
        look({key_vpn(k), off}, foreign ? 8'h55 : key_asid(k), w, u, res);
        if (foreign || !m_present[k]) begin
          exp = pack(0, 2'b01, 0, 0, '0);
          chk(res == exp, "R2", "random miss", 64'(res), 64'(exp));
        end else if (deny_f(m_prot[k], w, u)) begin
          exp = pack(0, 2'b10, m_ref[k], m_dirty[k], '0);
          chk(res == exp, "R3", "random refused", 64'(res), 64'(exp));
        end else begin
          exp = pack(1, 2'b00, m_ref[k], m_dirty[k], {m_pfn[k], off});
          chk(res == exp, "R1", "random hit", 64'(res), 64'(exp));
          m_ref[k] = 1;
          if (w) m_dirty[k] = 1;
        end
      end else begin
        do_flush();
        for (int j = 0; j < 32; j++) m_present[j] = 0;
      end
    end

    @(negedge clk);
    clear_in();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule